// File: doc/BRIEF.md
# Half-Bridge Driver Input Control

This block is the command front end of a two-channel gate driver for a half bridge. It takes an upper-switch command, a lower-switch command, a shutdown level and a lower-supply undervoltage flag. It produces one registered drive-enable per channel. All inputs are taken to be already synchronized to `clk`. The upper enable is meant to feed a separate level-shift block.

Each channel has its own sticky shutdown latch and its own four-state delay machine. The states are `ST_IDLE` (output off), `ST_ARMING` (turn-on delay counting), `ST_DRIVE` (output on) and `ST_RELEASING` (turn-off delay counting, output still on). The transitions are:

- **request**: `ST_IDLE` to `ST_ARMING`.
- **cancel**: `ST_ARMING` to `ST_IDLE`, when the request drops before the delay ends.
- **armed**: `ST_ARMING` to `ST_DRIVE`, when the delay ends.
- **drop**: `ST_DRIVE` to `ST_RELEASING`.
- **resume**: `ST_RELEASING` to `ST_DRIVE`, when the request returns.
- **released**: `ST_RELEASING` to `ST_IDLE`, when the delay ends.
- **force**: from any state to `ST_IDLE`, on shutdown, on a set latch, or on undervoltage for the lower channel.

The turn-on delay is longer than the turn-off delay. Both are set in clock cycles, and both channels use the same values.

Top module: `hb_input_ctrl`

## Requirements
- R1: While `rst_n` is 0 at a clock edge, both enables are 0 after that edge and both shutdown latches are cleared. After reset, a rising command turns its channel on with no further action.
- R2: When `shdn` is 1 at a clock edge, both enables are 0 after that edge. This holds even for a channel whose turn-on delay is still counting.
- R3: After `shdn` returns to 0, a channel stays off until a rising edge (0 then 1 on consecutive clock edges) of its own command is seen while `shdn` is 0. A command held high through the shutdown release does not clear the latch.
- R4: Each channel's latch is cleared only by that channel's own command edge. The other channel stays off.
- R5: When `lo_uv` is 1 at a clock edge, `lo_drv_en` is 0 after that edge. `hi_drv_en` is unaffected.
- R6: If `lo_cmd` is already 1 when `lo_uv` returns to 0, the lower channel turns on after the turn-on delay, with no new command edge.
- R7: A command that is 1 from clock edge E onward drives its enable to 1 after edge E+ON_DLY-1. With default parameters, the enable rises on the 12th edge.
- R8: A command that is 0 from clock edge E onward drives its enable to 0 after edge E+OFF_DLY-1. With default parameters, the enable falls on the 10th edge.
- R9: A command pulse shorter than ON_DLY cycles produces no output. A command dropout shorter than OFF_DLY cycles leaves the output on.
- R10: The channels are independent: one channel's command never changes the other channel's enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_cmd | input | 1 | Upper-switch command, 1 = on |
| lo_cmd | input | 1 | Lower-switch command, 1 = on |
| shdn | input | 1 | Shutdown level, 1 = shut down |
| lo_uv | input | 1 | Lower-supply undervoltage flag, 1 = undervoltage |
| hi_drv_en | output | 1 | Delayed, gated upper drive enable |
| lo_drv_en | output | 1 | Delayed, gated lower drive enable |

## Verification
The assertions check on every cycle that shutdown, undervoltage and reset force the enables off by the next edge. They also check that a latch only releases after a command edge taken while shutdown is low, and that an enable only rises when its request was present one cycle before. The exact on and off delay counts, the cancelling of short pulses and dropouts, the lower channel's turn-on when undervoltage releases, and per-channel latch clearing are shown only by the bench's directed scenarios.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ARMING    = 2'd1,
        ST_DRIVE     = 2'd2,
        ST_RELEASING = 2'd3
    } drv_state_t;
endpackage

// File: rtl/hb_shdn_gate.sv
// Per-channel sticky shutdown latch with command edge release.
module hb_shdn_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic shdn,
    output logic blocked
);
    logic cmd_q;
    logic latch_q;
    logic cmd_rise;

    assign cmd_rise = cmd & ~cmd_q;
    // latch is held by shutdown level, released by a fresh command edge
    assign blocked  = shdn | (latch_q & ~cmd_rise);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            cmd_q   <= cmd;
            latch_q <= blocked;
        end
    end

    a_r2_shdn_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> latch_q);
    a_r3_release_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_q) |-> $past(cmd_rise && !shdn));
endmodule

// File: rtl/hb_delay_fsm.sv
// Per-channel turn-on / turn-off propagation delay state machine.
module hb_delay_fsm
    import hb_pkg::*;
#(
    parameter int ON_DLY  = 12,
    parameter int OFF_DLY = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic force_off,
    output logic drv_en
);
    localparam int MAXD = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] ON_LOAD  = CW'(ON_DLY - 1);
    localparam logic [CW-1:0] OFF_LOAD = CW'(OFF_DLY - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    drv_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic req;

    assign req = cmd & ~force_off;

    initial begin
        if (ON_DLY < 2 || OFF_DLY < 2) $error("delays must be at least 2");
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (force_off) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req) begin
                    state_d = ST_ARMING;
                    cnt_d   = ON_LOAD;
                end
                ST_ARMING: begin
                    if (!req)              state_d = ST_IDLE;
                    else if (cnt_q == ONE) state_d = ST_DRIVE;
                    else                   cnt_d   = cnt_q - ONE;
                end
                ST_DRIVE: if (!req) begin
                    state_d = ST_RELEASING;
                    cnt_d   = OFF_LOAD;
                end
                ST_RELEASING: begin
                    if (req)               state_d = ST_DRIVE;
                    else if (cnt_q == ONE) state_d = ST_IDLE;
                    else                   cnt_d   = cnt_q - ONE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_DRIVE, ST_RELEASING: drv_en = 1'b1;
            default:                drv_en = 1'b0;
        endcase
    end

    a_r2_force_kills_output: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> !drv_en);
    a_r7_rise_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> $past(req));
    a_r8_fall_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> $past(!req));
endmodule

// File: rtl/hb_input_ctrl.sv
module hb_input_ctrl #(
    parameter int ON_DLY  = 12,
    parameter int OFF_DLY = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic shdn,
    input  logic lo_uv,
    output logic hi_drv_en,
    output logic lo_drv_en
);
    localparam int NCH = 2;  // index 0 = upper, 1 = lower

    logic [NCH-1:0] cmd_v, blocked_v, force_v, en_v;

    assign cmd_v = {lo_cmd, hi_cmd};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        hb_shdn_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd_v[g]),
            .shdn    (shdn),
            .blocked (blocked_v[g])
        );
        if (g == 1) begin : g_uv
            assign force_v[g] = blocked_v[g] | lo_uv;
        end else begin : g_nouv
            assign force_v[g] = blocked_v[g];
        end
        hb_delay_fsm #(.ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd_v[g]),
            .force_off (force_v[g]),
            .drv_en    (en_v[g])
        );
    end

    assign hi_drv_en = en_v[0];
    assign lo_drv_en = en_v[1];

    a_r1_reset_off: assert property (@(posedge clk)
        !rst_n |=> (!hi_drv_en && !lo_drv_en));
    a_r5_uv_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
        lo_uv |=> !lo_drv_en);
    a_r2_shdn_both_off: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> (!hi_drv_en && !lo_drv_en));
endmodule

// File: tb/tb_hb_input_ctrl.sv
module tb_hb_input_ctrl;
    localparam int ON_DLY  = 12;
    localparam int OFF_DLY = 10;

    logic clk = 1'b0;
    logic rst_n, hi_cmd, lo_cmd, shdn, lo_uv;
    logic hi_drv_en, lo_drv_en;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    hb_input_ctrl #(.ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) dut (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .shdn(shdn), .lo_uv(lo_uv), .hi_drv_en(hi_drv_en), .lo_drv_en(lo_drv_en)
    );

    task automatic chk(input string rq, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic nwait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hi_cmd = 0; lo_cmd = 0; shdn = 0; lo_uv = 0;
        nwait(3);
        chk("R1 hi off in reset", hi_drv_en, 1'b0);
        chk("R1 lo off in reset", lo_drv_en, 1'b0);
        rst_n = 1'b1;
        nwait(2);
    endtask

    task automatic t_delays();
        hi_cmd = 1;
        nwait(ON_DLY - 1);
        chk("R7 hi still off one edge early", hi_drv_en, 1'b0);
        nwait(1);
        chk("R7 hi on after ON_DLY (R1 no latch after reset)", hi_drv_en, 1'b1);
        chk("R10 lo untouched by hi", lo_drv_en, 1'b0);
        hi_cmd = 0;
        nwait(OFF_DLY - 1);
        chk("R8 hi still on one edge early", hi_drv_en, 1'b1);
        nwait(1);
        chk("R8 hi off after OFF_DLY", hi_drv_en, 1'b0);
        lo_cmd = 1;
        nwait(ON_DLY);
        chk("R7 lo on after ON_DLY", lo_drv_en, 1'b1);
        chk("R10 hi untouched by lo", hi_drv_en, 1'b0);
        lo_cmd = 0;
        nwait(OFF_DLY);
        chk("R8 lo off after OFF_DLY", lo_drv_en, 1'b0);
    endtask

    task automatic t_glitch();
        logic seen = 1'b0;
        hi_cmd = 1;
        nwait(ON_DLY - 2);
        hi_cmd = 0;
        for (int i = 0; i < 20; i++) begin
            nwait(1);
            if (hi_drv_en) seen = 1'b1;
        end
        chk("R9 short on pulse suppressed", seen, 1'b0);
        hi_cmd = 1;
        nwait(ON_DLY + 1);
        hi_cmd = 0;
        nwait(OFF_DLY - 2);
        hi_cmd = 1;
        seen = 1'b1;
        for (int i = 0; i < 15; i++) begin
            nwait(1);
            if (!hi_drv_en) seen = 1'b0;
        end
        chk("R9 short dropout keeps output on", seen, 1'b1);
    endtask

    task automatic t_shutdown();
        // hi already on; lo turn-on pending
        lo_cmd = 1;
        nwait(3);
        shdn = 1;
        nwait(1);
        chk("R2 hi forced off in one edge", hi_drv_en, 1'b0);
        chk("R2 pending lo turn-on cancelled", lo_drv_en, 1'b0);
        nwait(ON_DLY + 2);
        chk("R2 lo stays off during shutdown", lo_drv_en, 1'b0);
        shdn = 0;
        nwait(ON_DLY + 5);
        chk("R3 held hi command does not clear latch", hi_drv_en, 1'b0);
        chk("R3 held lo command does not clear latch", lo_drv_en, 1'b0);
        hi_cmd = 0;
        nwait(1);
        hi_cmd = 1;
        nwait(ON_DLY - 1);
        chk("R3 hi off before delay after fresh edge", hi_drv_en, 1'b0);
        nwait(1);
        chk("R3 fresh hi edge reactivates hi", hi_drv_en, 1'b1);
        chk("R4 lo latch still set", lo_drv_en, 1'b0);
        lo_cmd = 0;
        nwait(1);
        lo_cmd = 1;
        nwait(ON_DLY);
        chk("R4 lo cleared by its own edge", lo_drv_en, 1'b1);
    endtask

    task automatic t_uv();
        lo_uv = 1;
        nwait(1);
        chk("R5 lo forced off by undervoltage", lo_drv_en, 1'b0);
        chk("R5 hi unaffected by undervoltage", hi_drv_en, 1'b1);
        nwait(5);
        lo_uv = 0;
        nwait(ON_DLY - 1);
        chk("R6 lo off one edge before delay", lo_drv_en, 1'b0);
        nwait(1);
        chk("R6 lo on after release with held command", lo_drv_en, 1'b1);
    endtask

    initial begin
        t_reset();
        t_delays();
        t_glitch();
        t_shutdown();
        t_uv();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule